// File: doc/BRIEF.md
# Serial Display-Controller Command Port

This block is the serial slave port of a segment-display controller. A host frames each transfer by pulling an active-low select low. It then clocks bits in on the rising edge of a write strobe, and clocks read bits out with a read strobe. The first three bits of a frame choose its kind. One kind reads display memory, one writes display memory (a read-modify-write also fits inside this kind), and one carries mode commands. The block holds a 64-entry by 4-bit display memory and the mode registers that the analog bias, oscillator, tone and time-base logic elsewhere on the chip consume.

All strobes and the select are taken as already synchronous to `clk`. The block detects their edges internally, so one strobe edge is acted on at the clock edge where it is first seen. The port has no valid/ready handshake: the host paces every bit with a strobe, and the block accepts every strobe without back-pressure. The bidirectional data line is split into `data_in`, `data_out` and an output enable `data_oe`. A pad cell outside this block drives the line only while `data_oe` is high.

Top module: `dispctl_top`

## Requirements
- R1: After reset: system off, bias off, time base off, watchdog off, tone off, tone 2 kHz (`tone_4k`=0), clock source internal RC (`clk_src`=0), 2 commons (`com_sel`=00), 1/2 bias (`bias_third`=0), interrupt off, `tb_rate`=111, normal mode (`test_mode`=0), no clear pulses, `data_oe`=0, and every memory nibble is 0.
- R2: While the select is low, the first three write-strobe bits form the frame identifier, first bit most significant. 110 is a memory read, 101 is a memory write, and 100 is a command frame. Any other identifier makes the block ignore every strobe until the select goes high.
- R3: In memory frames, six address bits follow the identifier, most significant bit first. Each data nibble is then sent bit 0 first and bit 3 last. In a write frame, the memory entry is written once the fourth data bit has been received.
- R4: After each nibble, written or read, the frame address increments by one, and it wraps from 63 to 0. This lets consecutive nibbles fill or read successive addresses in one frame.
- R5: In a read frame, each falling edge of the read strobe presents the next bit (bit 0 first) of the addressed nibble on `data_out`, with `data_oe` high, one clock later. `data_oe` drops one clock after the read strobe rises, and it stays low whenever no read bit is being presented.
- R6: In a write frame, read strobes that come before a nibble's write bits present the current address's stored nibble, bit 0 first, without moving the address. The write bits that follow then overwrite that same entry (read-modify-write).
- R7: A command frame carries any number of 9-bit words back to back. The first 8 bits of a word, most significant first, form the command code, and the ninth bit is ignored.
- R8: Code 00000000 clears both system enable and bias on, and code 00000001 sets system enable. Codes 00000010 and 00000011 clear and set bias on. Codes 00000100 and 00000110 clear and set time base enable, and 00000101 and 00000111 clear and set watchdog enable. Codes 00001000 and 00001001 clear and set tone enable.
- R9: Codes 000101xx, 000110xx and 000111xx set `clk_src` to 1 (crystal), 0 (internal RC) and 2 (external) respectively. Code 000100xx has no effect.
- R10: Code 0010abxc loads `com_sel`=ab and `bias_third`=c when ab is 00, 01 or 10. When ab is 11, the whole command has no effect.
- R11: Code 010xxxxx sets `tone_4k` and 011xxxxx clears it. In code 100xexxx, bit e becomes `irq_en`. Code 101xxrrr loads `tb_rate`=rrr.
- R12: Code 11100000 sets `test_mode` and 11100011 clears it. Every code not listed in R8 to R13 leaves every output unchanged.
- R13: Code 00001101 raises `clr_tb` and code 00001111 raises `clr_wdt`, each for exactly one clock. Codes 00001100 and 00001110 raise neither.
- R14: Raising the select at any point ends the frame. A partly received address, nibble or command word is discarded with no effect, and the next frame starts with identifier capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| wr_n | input | 1 | Write strobe, bit taken on rising edge |
| rd_n | input | 1 | Read strobe, bit presented after falling edge |
| data_in | input | 1 | Serial data from the host |
| data_out | output | 1 | Serial read data |
| data_oe | output | 1 | High while the data line should be driven |
| sys_en | output | 1 | System oscillator enable |
| bias_on | output | 1 | Display bias generator enable |
| clk_src | output | 2 | 0 internal RC, 1 crystal, 2 external |
| bias_third | output | 1 | 1 selects 1/3 bias, 0 selects 1/2 |
| com_sel | output | 2 | 00 two, 01 three, 10 four commons |
| tone_en | output | 1 | Tone output enable |
| tone_4k | output | 1 | 1 selects 4 kHz tone, 0 selects 2 kHz |
| irq_en | output | 1 | Interrupt output enable |
| tb_en | output | 1 | Time base output enable |
| wdt_en | output | 1 | Watchdog flag output enable |
| tb_rate | output | 3 | Time base rate select |
| test_mode | output | 1 | Test mode flag |
| clr_tb | output | 1 | One-clock time base clear pulse |
| clr_wdt | output | 1 | One-clock watchdog clear pulse |

## Verification
The memory path is tried with asymmetric values: address 3, whose bit reversal is 48, and nibbles such as 0001 and 0010. A reversed bit order therefore lands in a visibly different place. Bursts that cross address 63 show the wrap. A read-modify-write frame shows that the read bits and the write bits refer to the same entry. For commands, each code family is sent with its ninth bit set to both values, together with near-miss codes (000100xx, ab=11, 11100001, 00001100). These tell decoded codes apart from ignored ones. Frames cut short by the select, and frames with an invalid identifier, show that partial input leaves no trace.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

  typedef enum logic [2:0] {
    FR_ID, FR_CMD, FR_ADDR, FR_WDATA, FR_RDATA, FR_SKIP
  } frame_state_e;

  localparam logic [2:0] ID_CMD  = 3'b100;
  localparam logic [2:0] ID_WR   = 3'b101;
  localparam logic [2:0] ID_RD   = 3'b110;

  localparam logic [1:0] CLK_RC   = 2'd0;
  localparam logic [1:0] CLK_XTAL = 2'd1;
  localparam logic [1:0] CLK_EXT  = 2'd2;

  typedef struct packed {
    logic       sys_en;
    logic       bias_on;
    logic [1:0] clk_src;
    logic       bias_third;
    logic [1:0] com_sel;
    logic       tone_en;
    logic       tone_4k;
    logic       irq_en;
    logic       tb_en;
    logic       wdt_en;
    logic [2:0] tb_rate;
    logic       test_mode;
  } mode_t;

  localparam mode_t MODE_RESET = '{
    sys_en: 1'b0, bias_on: 1'b0, clk_src: CLK_RC, bias_third: 1'b0,
    com_sel: 2'b00, tone_en: 1'b0, tone_4k: 1'b0, irq_en: 1'b0,
    tb_en: 1'b0, wdt_en: 1'b0, tb_rate: 3'b111, test_mode: 1'b0
  };

endpackage

// File: rtl/dispctl_frame_rx.sv
module dispctl_frame_rx
  import dispctl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 4,
  parameter int CMD_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              data_in,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              cmd_fire,
  output logic [CMD_W-2:0]  cmd_code,
  output logic              data_out,
  output logic              data_oe
);
  localparam int CNT_W = $clog2(CMD_W + 1);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  frame_state_e          state;
  logic [CNT_W-1:0]      cnt;
  logic [CMD_W-2:0]      shreg;
  logic [ADDR_W-1:0]     addr;
  logic [DATA_W-1:0]     nib;
  logic [BIT_W-1:0]      rcnt;
  logic                  wr_q, rd_q, dout, drive;
  logic                  wr_rise, rd_fall, rd_rise;
  logic [2:0]            id_word;

  assign wr_rise  = wr_n & ~wr_q;
  assign rd_fall  = ~rd_n & rd_q;
  assign rd_rise  = rd_n & ~rd_q;
  assign id_word  = {shreg[1:0], data_in};

  assign cmd_fire = ~cs_n & wr_rise & (state == FR_CMD) & (cnt == CNT_W'(CMD_W - 1));
  assign cmd_code = shreg;
  assign mem_we   = ~cs_n & wr_rise & (state == FR_WDATA) & (cnt == CNT_W'(DATA_W - 1));
  assign mem_addr = addr;
  always_comb begin
    mem_wdata = nib;
    mem_wdata[DATA_W-1] = data_in;
  end

  assign data_out = dout;
  assign data_oe  = drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FR_ID;
      cnt   <= '0;
      shreg <= '0;
      addr  <= '0;
      nib   <= '0;
      rcnt  <= '0;
      wr_q  <= 1'b1;
      rd_q  <= 1'b1;
      dout  <= 1'b0;
      drive <= 1'b0;
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_n;
      if (cs_n) begin
        state <= FR_ID;
        cnt   <= '0;
        shreg <= '0;
        rcnt  <= '0;
        drive <= 1'b0;
      end else if (wr_rise) begin
        unique case (state)
          FR_ID: begin
            shreg <= {shreg[CMD_W-3:0], data_in};
            if (cnt == CNT_W'(2)) begin
              cnt <= '0;
              unique case (id_word)
                ID_CMD:  state <= FR_CMD;
                ID_WR:   state <= FR_ADDR;
                ID_RD:   state <= FR_ADDR;
                default: state <= FR_SKIP;
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FR_CMD: begin
            shreg <= {shreg[CMD_W-3:0], data_in};
            cnt   <= (cnt == CNT_W'(CMD_W - 1)) ? '0 : cnt + 1'b1;
          end
          FR_ADDR: begin
            addr <= {addr[ADDR_W-2:0], data_in};
            if (cnt == CNT_W'(ADDR_W - 1)) begin
              cnt   <= '0;
              rcnt  <= '0;
              state <= (shreg[2:0] == ID_WR) ? FR_WDATA : FR_RDATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FR_WDATA: begin
            nib[cnt[BIT_W-1:0]] <= data_in;
            if (cnt == CNT_W'(DATA_W - 1)) begin
              cnt  <= '0;
              rcnt <= '0;
              addr <= addr + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end else if (rd_fall) begin
        if (state == FR_RDATA) begin
          dout  <= mem_rdata[cnt[BIT_W-1:0]];
          drive <= 1'b1;
          if (cnt == CNT_W'(DATA_W - 1)) begin
            cnt  <= '0;
            addr <= addr + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (state == FR_WDATA) begin
          dout  <= mem_rdata[rcnt];
          drive <= 1'b1;
          rcnt  <= rcnt + 1'b1;
        end
      end else if (rd_rise) begin
        drive <= 1'b0;
      end
    end
  end

  // R5
  oe_off_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !data_oe);

  // R4
  addr_step_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> mem_addr == $past(mem_addr) + 1'b1);

  // R2
  skip_holds_until_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FR_SKIP && !cs_n) |=> state == FR_SKIP);

  // R14
  deselect_returns_to_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (state == FR_ID && cnt == '0));

endmodule

// File: rtl/dispctl_ram.sv
module dispctl_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cells[g] <= '0;
      else if (we && addr == ADDR_W'(g))
        cells[g] <= wdata;
    end
  end

  assign rdata = cells[addr];

endmodule

// File: rtl/dispctl_mode_regs.sv
module dispctl_mode_regs
  import dispctl_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  logic [CODE_W-1:0] cmd_code,
  output mode_t             mode,
  output logic              clr_tb,
  output logic              clr_wdt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_RESET;
      clr_tb  <= 1'b0;
      clr_wdt <= 1'b0;
    end else begin
      clr_tb  <= 1'b0;
      clr_wdt <= 1'b0;
      if (cmd_fire) begin
        casez (cmd_code)
          8'b0000_0000: begin mode.sys_en <= 1'b0; mode.bias_on <= 1'b0; end
          8'b0000_0001: mode.sys_en  <= 1'b1;
          8'b0000_0010: mode.bias_on <= 1'b0;
          8'b0000_0011: mode.bias_on <= 1'b1;
          8'b0000_0100: mode.tb_en   <= 1'b0;
          8'b0000_0101: mode.wdt_en  <= 1'b0;
          8'b0000_0110: mode.tb_en   <= 1'b1;
          8'b0000_0111: mode.wdt_en  <= 1'b1;
          8'b0000_1000: mode.tone_en <= 1'b0;
          8'b0000_1001: mode.tone_en <= 1'b1;
          8'b0000_1101: clr_tb  <= 1'b1;
          8'b0000_1111: clr_wdt <= 1'b1;
          8'b0001_01??: mode.clk_src <= CLK_XTAL;
          8'b0001_10??: mode.clk_src <= CLK_RC;
          8'b0001_11??: mode.clk_src <= CLK_EXT;
          8'b0010_????: if (cmd_code[3:2] != 2'b11) begin
                          mode.com_sel    <= cmd_code[3:2];
                          mode.bias_third <= cmd_code[0];
                        end
          8'b010?_????: mode.tone_4k <= 1'b1;
          8'b011?_????: mode.tone_4k <= 1'b0;
          8'b100?_????: mode.irq_en  <= cmd_code[3];
          8'b101?_????: mode.tb_rate <= cmd_code[2:0];
          8'b1110_0000: mode.test_mode <= 1'b1;
          8'b1110_0011: mode.test_mode <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  // R8
  sys_off_drops_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_code == 8'h00) |=> (!mode.sys_en && !mode.bias_on));

  // R13
  clr_tb_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_tb |=> !clr_tb);

  // R13
  clr_wdt_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wdt |=> !clr_wdt);

  // R13
  clr_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_tb && clr_wdt));

  // R12
  idle_mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_fire) |-> $stable(mode));

endmodule

// File: rtl/dispctl_top.sv
module dispctl_top
  import dispctl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 4,
  parameter int CMD_W  = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       wr_n,
  input  logic       rd_n,
  input  logic       data_in,
  output logic       data_out,
  output logic       data_oe,
  output logic       sys_en,
  output logic       bias_on,
  output logic [1:0] clk_src,
  output logic       bias_third,
  output logic [1:0] com_sel,
  output logic       tone_en,
  output logic       tone_4k,
  output logic       irq_en,
  output logic       tb_en,
  output logic       wdt_en,
  output logic [2:0] tb_rate,
  output logic       test_mode,
  output logic       clr_tb,
  output logic       clr_wdt
);
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic              cmd_fire;
  logic [CMD_W-2:0]  cmd_code;
  mode_t             mode;

  dispctl_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .data_in(data_in), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cmd_fire(cmd_fire),
    .cmd_code(cmd_code), .data_out(data_out), .data_oe(data_oe)
  );

  dispctl_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );

  dispctl_mode_regs #(.CODE_W(CMD_W - 1)) u_mode (
    .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .cmd_code(cmd_code),
    .mode(mode), .clr_tb(clr_tb), .clr_wdt(clr_wdt)
  );

  assign sys_en     = mode.sys_en;
  assign bias_on    = mode.bias_on;
  assign clk_src    = mode.clk_src;
  assign bias_third = mode.bias_third;
  assign com_sel    = mode.com_sel;
  assign tone_en    = mode.tone_en;
  assign tone_4k    = mode.tone_4k;
  assign irq_en     = mode.irq_en;
  assign tb_en      = mode.tb_en;
  assign wdt_en     = mode.wdt_en;
  assign tb_rate    = mode.tb_rate;
  assign test_mode  = mode.test_mode;

endmodule

// File: tb/test_dispctl_top.sv
`timescale 1ns/1ps
module test_dispctl_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, data_in = 1'b0;
  logic data_out, data_oe, sys_en, bias_on, bias_third, tone_en, tone_4k;
  logic irq_en, tb_en, wdt_en, test_mode, clr_tb, clr_wdt;
  logic [1:0] clk_src, com_sel;
  logic [2:0] tb_rate;

  dispctl_top i_dispctl_top (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .sys_en(sys_en), .bias_on(bias_on), .clk_src(clk_src),
    .bias_third(bias_third), .com_sel(com_sel), .tone_en(tone_en),
    .tone_4k(tone_4k), .irq_en(irq_en), .tb_en(tb_en), .wdt_en(wdt_en),
    .tb_rate(tb_rate), .test_mode(test_mode), .clr_tb(clr_tb), .clr_wdt(clr_wdt)
  );

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0, cmp_on = 0;

  // behavioural reference state
  logic e_sys = 0, e_bias = 0, e_third = 0, e_tone = 0, e_4k = 0, e_irq = 0;
  logic e_tb = 0, e_wdt = 0, e_test = 0, e_ctb = 0, e_cwdt = 0;
  logic [1:0] e_clk = 0, e_com = 0;
  logic [2:0] e_rate = 3'b111;
  logic [3:0] mem_m [64];
  int cur_addr = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // compares every mode output against the model on every clock (R8 R9 R10 R11 R12 R13)
  always @(negedge clk) if (cmp_on) begin
    automatic logic [17:0] a = {sys_en, bias_on, clk_src, bias_third, com_sel, tone_en,
                                tone_4k, irq_en, tb_en, wdt_en, tb_rate, test_mode, clr_tb, clr_wdt};
    automatic logic [17:0] e = {e_sys, e_bias, e_clk, e_third, e_com, e_tone,
                                e_4k, e_irq, e_tb, e_wdt, e_rate, e_test, e_ctb, e_cwdt};
    check(a === e, "R8 R9 R10 R11 R12 R13 mode outputs", int'(a), int'(e));
  end

  function automatic void apply_cmd(input logic [7:0] c);
    casez (c)
      8'h00: begin e_sys = 0; e_bias = 0; end
      8'h01: e_sys = 1;
      8'h02: e_bias = 0;
      8'h03: e_bias = 1;
      8'h04: e_tb = 0;
      8'h05: e_wdt = 0;
      8'h06: e_tb = 1;
      8'h07: e_wdt = 1;
      8'h08: e_tone = 0;
      8'h09: e_tone = 1;
      8'h0D: e_ctb = 1;
      8'h0F: e_cwdt = 1;
      8'b0001_01??: e_clk = 2'd1;
      8'b0001_10??: e_clk = 2'd0;
      8'b0001_11??: e_clk = 2'd2;
      8'b0010_????: if (c[3:2] != 2'b11) begin e_com = c[3:2]; e_third = c[0]; end
      8'b010?_????: e_4k = 1;
      8'b011?_????: e_4k = 0;
      8'b100?_????: e_irq = c[3];
      8'b101?_????: e_rate = c[2:0];
      8'hE0: e_test = 1;
      8'hE3: e_test = 0;
      default: ;
    endcase
  endfunction

  task automatic wr_bit(input logic b);
    @(negedge clk); data_in = b; wr_n = 0;
    @(negedge clk); wr_n = 1;
    @(posedge clk); #1;
  endtask

  task automatic send_bits(input int v, input int n);
    for (int i = n - 1; i >= 0; i--) wr_bit(v[i]);
  endtask

  task automatic start_frame(input logic [2:0] id);
    @(negedge clk); cs_n = 0;
    send_bits(int'(id), 3);
  endtask

  task automatic end_frame();
    @(negedge clk); cs_n = 1; wr_n = 1; rd_n = 1;
    @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] c, input logic ninth);
    send_bits(int'(c), 8);
    wr_bit(ninth);
    apply_cmd(c);
    @(posedge clk); #1;
    e_ctb = 0; e_cwdt = 0;
  endtask

  task automatic write_nib(input logic [3:0] d);
    for (int i = 0; i < 4; i++) wr_bit(d[i]);
    mem_m[cur_addr] = d;
    cur_addr = (cur_addr + 1) % 64;
  endtask

  task automatic rd_bit(input logic exp, input string req);
    @(negedge clk); rd_n = 0;
    @(negedge clk);
    check(data_oe === 1'b1, {req, " oe during read"}, int'(data_oe), 1);
    check(data_out === exp, {req, " read bit"}, int'(data_out), int'(exp));
    rd_n = 1;
    @(negedge clk);
    check(data_oe === 1'b0, "R5 oe released", int'(data_oe), 0);
  endtask

  task automatic read_nib(input string req);
    for (int i = 0; i < 4; i++) rd_bit(mem_m[cur_addr][i], req);
    cur_addr = (cur_addr + 1) % 64;
  endtask

  task automatic set_addr(input int a);
    send_bits(a, 6);
    cur_addr = a;
  endtask

  task automatic rd_idle(input string req);
    @(negedge clk); rd_n = 0;
    @(negedge clk);
    check(data_oe === 1'b0, req, int'(data_oe), 0);
    rd_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem_m[i] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(tb_rate === 3'b111 && clk_src === 2'd0 && !sys_en && !bias_on && !test_mode,
          "R1 reset modes", int'({sys_en, bias_on, clk_src, tb_rate, test_mode}), 'h0e);
    check(data_oe === 1'b0, "R1 oe at reset", int'(data_oe), 0);
    cmp_on = 1;

    // R1 memory cleared, R3 address MSB first (address 48 read)
    start_frame(3'b110); set_addr(48); read_nib("R1 memory zero"); end_frame();

    // R8 power and output enables, R7 back to back words with ninth bit both values
    start_frame(3'b100);
    cmd(8'h01, 1); cmd(8'h03, 0); cmd(8'h06, 1); cmd(8'h07, 0); cmd(8'h09, 1);
    cmd(8'h05, 0); cmd(8'h04, 1); cmd(8'h08, 0); cmd(8'h02, 1); cmd(8'h03, 0);
    cmd(8'h00, 1);
    end_frame();

    // R9 clock source, R10 bias, R11 tone irq rate, R12 test and unlisted codes
    start_frame(3'b100);
    cmd(8'h14, 1); cmd(8'h1F, 0); cmd(8'h10, 1); cmd(8'h1A, 0); cmd(8'h17, 1);
    cmd(8'h25, 0); cmd(8'h28, 1); cmd(8'h2D, 0);
    cmd(8'h5F, 1); cmd(8'h60, 0); cmd(8'h98, 1); cmd(8'h90, 0); cmd(8'h88, 1);
    cmd(8'hAA, 0); cmd(8'hB5, 1);
    cmd(8'hE0, 0); cmd(8'hE1, 1); cmd(8'hFF, 0); cmd(8'hE3, 1);
    // R13 clear pulses and near misses
    cmd(8'h0D, 0); cmd(8'h0F, 1); cmd(8'h0C, 0); cmd(8'h0E, 1);
    end_frame();

    // R3 R4 write burst across the wrap
    start_frame(3'b101); set_addr(62);
    write_nib(4'hA); write_nib(4'h1); write_nib(4'h2);
    end_frame();
    // R5 R4 read back across the wrap
    start_frame(3'b110); set_addr(62);
    read_nib("R5 burst"); read_nib("R4 wrap 63"); read_nib("R4 wrap 0");
    end_frame();

    // R3 bit order: address 3 (reverse would be 48), nibble 0010
    start_frame(3'b101); set_addr(3); write_nib(4'h2); end_frame();
    start_frame(3'b110); set_addr(48); read_nib("R3 reversed address untouched"); end_frame();
    start_frame(3'b110); set_addr(3); read_nib("R3 data order"); end_frame();

    // R6 read-modify-write on address 3
    start_frame(3'b101); set_addr(3);
    for (int i = 0; i < 4; i++) rd_bit(mem_m[3][i], "R6 rmw read");
    write_nib(4'hC);
    for (int i = 0; i < 4; i++) rd_bit(mem_m[4][i], "R6 rmw next read");
    write_nib(4'h7);
    end_frame();
    start_frame(3'b110); set_addr(3); read_nib("R6 rmw result"); read_nib("R6 rmw next"); end_frame();

    // R14 aborts: mid address, mid nibble, mid command
    start_frame(3'b101); send_bits(10, 3); end_frame();
    start_frame(3'b101); set_addr(11); wr_bit(1); wr_bit(1); end_frame();
    start_frame(3'b110); set_addr(11); read_nib("R14 partial nibble dropped"); end_frame();
    start_frame(3'b100); send_bits(8'h01, 5); end_frame();
    check(sys_en === 1'b0, "R14 partial command dropped", int'(sys_en), 0);

    // R2 invalid identifier ignores everything until deselect
    start_frame(3'b111); send_bits(8'h01, 8); wr_bit(0);
    rd_idle("R2 no drive after invalid id");
    end_frame();
    check(sys_en === 1'b0, "R2 invalid id command ignored", int'(sys_en), 0);
    // R2 then a valid command frame still works
    start_frame(3'b100); cmd(8'h01, 0); end_frame();
    check(sys_en === 1'b1, "R2 recovery after deselect", int'(sys_en), 1);

    // R5 oe stays low with read strobes outside a read phase
    start_frame(3'b100); rd_idle("R5 no drive in command frame"); end_frame();

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule